// File: doc/BRIEF.md
# USB Root Hub Port Status and Control Register

This block holds the status and control state of one downstream port of a USB host root hub and sequences the timed operations on it. Host software reads a 32-bit word that shows the live port state in the low bits and the latched change flags in bits 20..16. It writes the same word to issue commands: enable, disable, suspend, resume, bus reset and power. A 1 ms tick input times the bus reset and the resume sequence. The hub's line logic supplies event inputs for device connect, low-speed detect, overcurrent and hardware-initiated disable.

The change flags are write-1-to-clear. Only hardware events and completed timed sequences can set them, and their OR drives the interrupt line. While a bus reset runs, the block asserts a reset-signalling request for a programmable number of ticks. A resume drives resume signalling for a programmable number of ticks, then an end-of-packet request for a few clock cycles, then waits out a resynchronisation delay before it reports completion.

Top module: `rh_port_status`

## Requirements
- R1: After reset every register bit reads 0 and the outputs bus_reset_o, resume_o, eop_o and irq_o are 0.
- R2: Read fields are: bit 0 connected, bit 1 enabled, bit 2 suspended, bit 3 overcurrent, bit 4 reset active, bit 8 power, bit 9 low-speed device. The change flags are bit 16 connect, bit 17 enable, bit 18 suspend, bit 19 overcurrent and bit 20 reset. Every other bit reads 0, and writing 1 to it has no effect.
- R3: Writing 1 to a change flag clears it. Writing 0 leaves it unchanged. A hardware set in the same cycle takes priority over the clear. No software write ever sets a change flag.
- R4: Writing 1 to bit 4 while a device is connected and no sequence is running asserts bus_reset_o and sets bit 4. With no device connected, the same write sets the connect change flag (bit 16) and starts nothing.
- R5: A bus reset ends on the RESET_MS-th tick after it starts (default 10). At that point bit 4 clears, the port becomes enabled, bit 20 sets and bit 18 clears, all in the same cycle.
- R6: Writing 1 to bit 2 sets the suspended bit only when the port is enabled and idle. On a disabled port the write has no effect.
- R7: Writing 1 to bit 3 while suspended starts a resume. resume_o stays high for RESUME_MS ticks (default 20), then eop_o stays high for EOP_CLKS clock cycles (default 3), then RESYNC_MS ticks pass (default 3). After that the suspended bit clears and bit 18 sets.
- R8: Writing 1 to bit 1 enables a connected port, and writing 1 to bit 0 disables it. Neither write sets the enable change flag (bit 17).
- R9: A hw_disable pulse on an enabled port clears bit 1 and sets bit 17. On an already disabled port it sets nothing.
- R10: A change on dev_connect updates bit 0 one cycle later and sets bit 16. A disconnect also clears bits 1 and 2, sets bit 17 if the port was enabled, and aborts any running sequence without setting its completion flag.
- R11: Bit 3 follows the overcurrent input. When per_port_oc is 1, every change of bit 3 sets bit 19. When per_port_oc is 0, bit 19 is never set.
- R12: irq_o is high exactly when at least one of bits 20..16 is set.
- R13: Writing 1 to bit 8 switches port power on, and writing 1 to bit 9 switches it off. If both are written together, switching on wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| dev_connect | input | 1 | Device present on the port |
| dev_lowspeed | input | 1 | Attached device is low speed |
| overcur | input | 1 | Overcurrent condition on the port |
| per_port_oc | input | 1 | Overcurrent is reported per port |
| hw_disable | input | 1 | Hardware event that disables the port |
| bus_reset_o | output | 1 | Request for bus reset signalling |
| resume_o | output | 1 | Request for resume signalling |
| eop_o | output | 1 | Request for a low-speed end-of-packet |
| irq_o | output | 1 | Interrupt, OR of the change flags |

## Verification
The assertions check the cycle-level rules on every clock. They confirm that a change flag rises only on a hardware set, clears one cycle after a 1 is written to it, and holds otherwise. They also check that a rising reset flag coincides with a cleared suspend flag, that the enable flag rises only together with a hardware loss of enable, that a disconnect or overcurrent change lands in the right flag one cycle later, and that the end-of-packet follows the resume pulse. The tick-counted durations and the exact read word after each command can only be shown by the bench scenarios. The same holds for the write-ignored cases: suspending a disabled port, and writing the unused bits.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_RESET,
      SQ_PULSE,
      SQ_EOP,
      SQ_SYNC
   } seq_st_t;

   // status bit positions decoded by host software
   localparam int ST_CONN   = 0;
   localparam int ST_ENAB   = 1;
   localparam int ST_SUSP   = 2;
   localparam int ST_OCUR   = 3;
   localparam int ST_RSTG   = 4;
   localparam int ST_PWR_ON = 8;
   localparam int ST_PWR_OF = 9;

   // change flag vector: index within the vector, base bit in the word
   localparam int CHG_N    = 5;
   localparam int CHG_BASE = 16;
   localparam int CH_CONN  = 0;
   localparam int CH_ENAB  = 1;
   localparam int CH_SUSP  = 2;
   localparam int CH_OCUR  = 3;
   localparam int CH_RSTG  = 4;

endpackage

// File: rtl/rh_seq_timer.sv
module rh_seq_timer
   import rh_port_pkg::*;
#(
   parameter int RESET_MS  = 10,
   parameter int RESUME_MS = 20,
   parameter int RESYNC_MS = 3,
   parameter int EOP_CLKS  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_ms,
   input  logic start_reset_i,
   input  logic start_resume_i,
   input  logic abort_i,
   output logic busy_o,
   output logic rst_act_o,
   output logic res_act_o,
   output logic eop_act_o,
   output logic rst_done_o,
   output logic res_done_o
);

   localparam int MAX_A = (RESET_MS > RESUME_MS) ? RESET_MS : RESUME_MS;
   localparam int MAX_B = (RESYNC_MS > EOP_CLKS) ? RESYNC_MS : EOP_CLKS;
   localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CW    = $clog2(MAXD + 1);

   generate
      if (RESET_MS < 1 || RESUME_MS < 1 || RESYNC_MS < 1 || EOP_CLKS < 1) begin : g_bad_len
         $error("rh_seq_timer: every duration must be at least 1");
      end
   endgenerate

   seq_st_t       st_q;
   logic [CW-1:0] cnt_q;
   logic          rst_last, pulse_last, eop_last, sync_last;

   assign rst_last   = cnt_q == CW'(RESET_MS - 1);
   assign pulse_last = cnt_q == CW'(RESUME_MS - 1);
   assign eop_last   = cnt_q == CW'(EOP_CLKS - 1);
   assign sync_last  = cnt_q == CW'(RESYNC_MS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else if (abort_i) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               cnt_q <= '0;
               if (start_reset_i)       st_q <= SQ_RESET;
               else if (start_resume_i) st_q <= SQ_PULSE;
            end
            SQ_RESET: if (tick_ms) begin
               if (rst_last) begin st_q <= SQ_IDLE; cnt_q <= '0; end
               else cnt_q <= cnt_q + 1'b1;
            end
            SQ_PULSE: if (tick_ms) begin
               if (pulse_last) begin st_q <= SQ_EOP; cnt_q <= '0; end
               else cnt_q <= cnt_q + 1'b1;
            end
            SQ_EOP: begin
               if (eop_last) begin st_q <= SQ_SYNC; cnt_q <= '0; end
               else cnt_q <= cnt_q + 1'b1;
            end
            SQ_SYNC: if (tick_ms) begin
               if (sync_last) begin st_q <= SQ_IDLE; cnt_q <= '0; end
               else cnt_q <= cnt_q + 1'b1;
            end
            default: begin st_q <= SQ_IDLE; cnt_q <= '0; end
         endcase
      end
   end

   assign busy_o     = st_q != SQ_IDLE;
   assign rst_act_o  = st_q == SQ_RESET;
   assign res_act_o  = st_q == SQ_PULSE;
   assign eop_act_o  = st_q == SQ_EOP;
   assign rst_done_o = (st_q == SQ_RESET) && tick_ms && rst_last && !abort_i;
   assign res_done_o = (st_q == SQ_SYNC) && tick_ms && sync_last && !abort_i;

   // R7: the end-of-packet phase follows the resume pulse unless aborted
   a_r7_eop_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(res_act_o) && !$past(abort_i)) |-> eop_act_o);

   // R5: a reset phase is left only by completion or abort
   a_r5_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_act_o) |-> ($past(rst_done_o) || $past(abort_i)));

endmodule

// File: rtl/rh_chg_bits.sv
module rh_chg_bits #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] hw_clr_i,
   input  logic [N-1:0] sw_clr_i,
   output logic [N-1:0] q_o
);

   generate
      if (N < 1) begin : g_bad_n
         $error("rh_chg_bits: N must be at least 1");
      end
      for (genvar g = 0; g < N; g++) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        flag_q <= 1'b0;
            else if (set_i[g])                 flag_q <= 1'b1;
            else if (hw_clr_i[g] || sw_clr_i[g]) flag_q <= 1'b0;
         end
         assign q_o[g] = flag_q;

         // R3: a flag rises only on a hardware set
         a_r3_set_only_hw: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q_o[g]) |-> $past(set_i[g]));
         // R3: writing 1 clears when no set competes
         a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr_i[g] && !set_i[g]) |=> !q_o[g]);
         // R3: with no clear request a set flag holds
         a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[g] && !sw_clr_i[g] && !hw_clr_i[g]) |=> q_o[g]);
      end
   endgenerate

endmodule

// File: rtl/rh_port_status.sv
module rh_port_status
   import rh_port_pkg::*;
#(
   parameter int RESET_MS  = 10,
   parameter int RESUME_MS = 20,
   parameter int RESYNC_MS = 3,
   parameter int EOP_CLKS  = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_ms,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   input  logic        dev_connect,
   input  logic        dev_lowspeed,
   input  logic        overcur,
   input  logic        per_port_oc,
   input  logic        hw_disable,
   output logic        bus_reset_o,
   output logic        resume_o,
   output logic        eop_o,
   output logic        irq_o
);

   localparam int DW = 32;

   logic [DW-1:0]    w;
   logic             ccs_q, enab_q, susp_q, ocur_q, pwr_q, lowspd_q;
   logic             disc_evt, conn_evt;
   logic             start_reset, start_resume;
   logic             busy, rst_act, res_act, eop_act, rst_done, res_done;
   logic [CHG_N-1:0] chg_set, chg_hwclr, chg_swclr, chg_q;
   logic             unused_wbits;

   assign w            = wr_en ? wr_data : '0;
   assign unused_wbits = ^{w[31:21], w[15:10], w[7:5]};

   assign conn_evt     = dev_connect != ccs_q;
   assign disc_evt     = ccs_q && !dev_connect;
   assign start_reset  = w[ST_RSTG] && ccs_q && !busy && !disc_evt;
   assign start_resume = w[ST_OCUR] && susp_q && !busy && !disc_evt;

   rh_seq_timer #(
      .RESET_MS (RESET_MS),
      .RESUME_MS(RESUME_MS),
      .RESYNC_MS(RESYNC_MS),
      .EOP_CLKS (EOP_CLKS)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_ms       (tick_ms),
      .start_reset_i (start_reset),
      .start_resume_i(start_resume),
      .abort_i       (disc_evt),
      .busy_o        (busy),
      .rst_act_o     (rst_act),
      .res_act_o     (res_act),
      .eop_act_o     (eop_act),
      .rst_done_o    (rst_done),
      .res_done_o    (res_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccs_q    <= 1'b0;
         enab_q   <= 1'b0;
         susp_q   <= 1'b0;
         ocur_q   <= 1'b0;
         pwr_q    <= 1'b0;
         lowspd_q <= 1'b0;
      end else begin
         ccs_q    <= dev_connect;
         lowspd_q <= dev_connect && dev_lowspeed;
         ocur_q   <= overcur;

         if (disc_evt || hw_disable)    enab_q <= 1'b0;
         else if (rst_done)             enab_q <= 1'b1;
         else if (w[ST_CONN])           enab_q <= 1'b0;
         else if (w[ST_ENAB] && ccs_q)  enab_q <= 1'b1;

         if (disc_evt || res_done || rst_done)       susp_q <= 1'b0;
         else if (w[ST_SUSP] && enab_q && !busy)     susp_q <= 1'b1;

         if (w[ST_PWR_ON])      pwr_q <= 1'b1;
         else if (w[ST_PWR_OF]) pwr_q <= 1'b0;
      end
   end

   always_comb begin
      chg_set            = '0;
      chg_set[CH_CONN]   = conn_evt || (w[ST_RSTG] && !ccs_q);
      chg_set[CH_ENAB]   = enab_q && (disc_evt || hw_disable);
      chg_set[CH_SUSP]   = res_done;
      chg_set[CH_OCUR]   = per_port_oc && (overcur != ocur_q);
      chg_set[CH_RSTG]   = rst_done;
      chg_hwclr          = '0;
      chg_hwclr[CH_SUSP] = rst_done;
      chg_swclr          = w[CHG_BASE +: CHG_N];
   end

   rh_chg_bits #(.N(CHG_N)) u_chg (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (chg_set),
      .hw_clr_i(chg_hwclr),
      .sw_clr_i(chg_swclr),
      .q_o     (chg_q)
   );

   always_comb begin
      rd_data                       = '0;
      rd_data[ST_CONN]              = ccs_q;
      rd_data[ST_ENAB]              = enab_q;
      rd_data[ST_SUSP]              = susp_q;
      rd_data[ST_OCUR]              = ocur_q;
      rd_data[ST_RSTG]              = rst_act;
      rd_data[ST_PWR_ON]            = pwr_q;
      rd_data[ST_PWR_OF]            = lowspd_q;
      rd_data[CHG_BASE +: CHG_N]    = chg_q;
   end

   assign bus_reset_o = rst_act;
   assign resume_o    = res_act;
   assign eop_o       = eop_act;
   assign irq_o       = |chg_q;

   // R12: interrupt tracks the readable change field
   a_r12_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (rd_data[20:16] != 5'd0));
   // R5: reset completion clears the resume-complete flag
   a_r5_prsc_clears_pssc: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_q[CH_RSTG]) |-> (!chg_q[CH_SUSP] && !rst_act));
   // R9: the enable change flag rises only with a hardware loss of enable
   a_r9_pesc_on_hw_loss: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_q[CH_ENAB]) |-> $fell(enab_q));
   // R10: disconnect disables and flags the connect change
   a_r10_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
      (ccs_q && !dev_connect) |=> (!enab_q && chg_q[CH_CONN] && !rst_act && !res_act));
   // R4: reset request without a device only flags the connect change
   a_r4_no_device: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[ST_RSTG] && !ccs_q) |=> (chg_q[CH_CONN] && !rst_act));
   // R11: per-port overcurrent changes are flagged
   a_r11_ocic: assert property (@(posedge clk) disable iff (!rst_n)
      (per_port_oc && (overcur != ocur_q)) |=> chg_q[CH_OCUR]);
   // R6: suspend only on an enabled port
   a_r6_susp_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp_q) |-> $past(enab_q));

endmodule

// File: tb/rh_port_status_bench.sv
module rh_port_status_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_ms = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        dev_connect = 1'b0;
   logic        dev_lowspeed = 1'b0;
   logic        overcur = 1'b0;
   logic        per_port_oc = 1'b0;
   logic        hw_disable = 1'b0;
   logic        bus_reset_o, resume_o, eop_o, irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   rh_port_status u_rh_port_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_ms     (tick_ms),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .dev_connect (dev_connect),
      .dev_lowspeed(dev_lowspeed),
      .overcur     (overcur),
      .per_port_oc (per_port_oc),
      .hw_disable  (hw_disable),
      .bus_reset_o (bus_reset_o),
      .resume_o    (resume_o),
      .eop_o       (eop_o),
      .irq_o       (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_ms = 1'b1;
         @(negedge clk);
         tick_ms = 1'b0;
      end
   endtask

   task automatic hw_pulse;
      @(negedge clk);
      hw_disable = 1'b1;
      @(negedge clk);
      hw_disable = 1'b0;
   endtask

   task automatic t_reset_state;
      chk("R1 read word", rd_data, 32'h0);
      chk("R1 outputs", {28'd0, bus_reset_o, resume_o, eop_o, irq_o}, 32'h0);
   endtask

   task automatic t_w1c;
      wr(32'h0000_0010);
      chk("R4 reset without device flags connect", rd_data, 32'h0001_0000);
      chk("R4 no reset signalling", {31'd0, bus_reset_o}, 32'd0);
      chk("R12 irq on flag", {31'd0, irq_o}, 32'd1);
      wr(32'h0);
      chk("R3 write 0 keeps flag", rd_data, 32'h0001_0000);
      wr(32'h0001_0000);
      chk("R3 write 1 clears flag", rd_data, 32'h0);
      chk("R12 irq low", {31'd0, irq_o}, 32'd0);
   endtask

   task automatic t_connect;
      @(negedge clk);
      dev_connect = 1'b1;
      @(negedge clk);
      chk("R10 connect flags", rd_data, 32'h0001_0001);
      wr(32'h0001_0000);
      chk("R3 clear connect flag", rd_data, 32'h1);
   endtask

   task automatic t_port_reset;
      wr(32'h0000_0010);
      chk("R4 reset started", rd_data, 32'h11);
      chk("R4 bus_reset_o high", {31'd0, bus_reset_o}, 32'd1);
      ticks(9);
      chk("R5 still in reset after 9 ticks", rd_data, 32'h11);
      ticks(1);
      chk("R5 reset complete word", rd_data, 32'h0010_0003);
      chk("R5 bus_reset_o low", {31'd0, bus_reset_o}, 32'd0);
      chk("R12 irq on reset flag", {31'd0, irq_o}, 32'd1);
      wr(32'h0010_0000);
      chk("R3 clear reset flag", rd_data, 32'h3);
   endtask

   task automatic t_resume;
      int n;
      wr(32'h4);
      chk("R6 suspend on enabled port", rd_data, 32'h7);
      wr(32'h8);
      chk("R7 resume_o high", {30'd0, resume_o, eop_o}, 32'b10);
      ticks(19);
      chk("R7 resume after 19 ticks", {30'd0, resume_o, eop_o}, 32'b10);
      ticks(1);
      n = 0;
      while (eop_o && n < 50) begin
         n++;
         @(negedge clk);
      end
      chk("R7 eop length in cycles", n, 32'd3);
      chk("R7 resume_o low", {31'd0, resume_o}, 32'd0);
      ticks(2);
      chk("R7 not complete before resync ends", rd_data, 32'h7);
      ticks(1);
      chk("R7 resume complete word", rd_data, 32'h0004_0003);
      wr(32'h10);
      ticks(10);
      chk("R5 reset clears resume flag", rd_data, 32'h0010_0003);
      wr(32'h0010_0000);
      chk("R3 clear after reset", rd_data, 32'h3);
   endtask

   task automatic t_sw_enable;
      wr(32'h1);
      chk("R8 software disable no flag", rd_data, 32'h1);
      wr(32'h4);
      chk("R6 suspend ignored when disabled", rd_data, 32'h1);
      wr(32'h2);
      chk("R8 software enable no flag", rd_data, 32'h3);
   endtask

   task automatic t_hw_disable;
      hw_pulse();
      chk("R9 hardware disable flags", rd_data, 32'h0002_0001);
      wr(32'h0002_0000);
      hw_pulse();
      chk("R9 disabled port no flag", rd_data, 32'h1);
      wr(32'h2);
      chk("R8 re-enable", rd_data, 32'h3);
   endtask

   task automatic t_overcurrent;
      @(negedge clk);
      overcur = 1'b1;
      @(negedge clk);
      chk("R11 shared mode no flag", rd_data, 32'hB);
      overcur = 1'b0;
      @(negedge clk);
      per_port_oc = 1'b1;
      overcur = 1'b1;
      @(negedge clk);
      chk("R11 per-port flag on rise", rd_data, 32'h0008_000B);
      overcur = 1'b0;
      @(negedge clk);
      chk("R11 flag held after fall", rd_data, 32'h0008_0003);
      wr(32'h0008_0000);
      chk("R11 flag cleared", rd_data, 32'h3);
   endtask

   task automatic t_power;
      wr(32'h100);
      chk("R13 power on", rd_data, 32'h103);
      wr(32'h200);
      chk("R13 power off", rd_data, 32'h3);
   endtask

   task automatic t_disconnect;
      wr(32'h10);
      chk("R4 reset before disconnect", rd_data, 32'h13);
      ticks(3);
      @(negedge clk);
      dev_connect = 1'b0;
      @(negedge clk);
      chk("R10 disconnect word", rd_data, 32'h0003_0000);
      chk("R10 reset aborted", {31'd0, bus_reset_o}, 32'd0);
      ticks(10);
      chk("R10 no reset completion", rd_data, 32'h0003_0000);
      wr(32'h0003_0000);
      chk("R3 clear both flags", rd_data, 32'h0);
   endtask

   task automatic t_lowspeed_unused;
      @(negedge clk);
      dev_lowspeed = 1'b1;
      dev_connect = 1'b1;
      @(negedge clk);
      chk("R2 low-speed connect word", rd_data, 32'h0001_0201);
      wr(32'hFFE0_FCE0);
      chk("R2 unused bits ignored", rd_data, 32'h0001_0201);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_w1c();
      t_connect();
      t_port_reset();
      t_resume();
      t_sw_enable();
      t_hw_disable();
      t_overcurrent();
      t_power();
      t_disconnect();
      t_lowspeed_unused();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule